// File: doc/BRIEF.md
# Flash Status Register Protection Unit

This block holds the three status bytes of a serial flash device and decides whether each request to rewrite them goes through. It receives already-decoded commands: an opcode strobe with up to three data bytes and a count of how many of them are valid. It also sees a write-protect pin (active low), a power-cycle pulse and a busy flag from the array sequencer. Each protection and configuration bit exists twice. The persistent copy survives power cycles. The working copy is what the outputs show and what the protection decision uses.

Which write-enable opcode comes before a write-status command picks the copy that gets written. 06h writes the persistent copy, and the working copy follows it. 50h writes only the working copy, which the next power cycle reloads from the persistent one. The two protect bits and the pin together select one of four protection levels: open, pin-gated, locked until the next power cycle, and locked for good. The four security lock bits can only be set, never cleared. The third status byte lives only in the working copy and is always writable through the 50h path. The quad-enable bit is driven out, and its complement is driven out as the hold-function enable.

Top module: `sreg_guard`

## Requirements
- R1: After reset, sr1_o is 00h apart from bit 0, sr2_o is 04h (lock bit 0 in SR2 bit 2 reads 1), sr3_o is 00h, quad_en_o is 0, hold_en_o is 1 and wr_ok_o is 0.
- R2: Opcodes 06h and 50h set WEL (SR1 bit 1) one cycle later. Any 01h command clears WEL. A 01h command that arrives with WEL clear changes no status bit.
- R3: With protect bits SRP1 (SR2 bit 0) and SRP0 (SR1 bit 7) at (0,0), a write-enabled 01h updates SR1 bits 7..2 from data byte 0 whatever the protect pin level.
- R4: With (SRP1,SRP0) = (0,1) and QE = 0, a 01h is rejected while wp_n_i is low and accepted after a write enable while wp_n_i is high.
- R5: With (SRP1,SRP0) = (1,0), every 01h update of SR1/SR2 is rejected. A power-cycle pulse returns both bits to (0,0).
- R6: With (SRP1,SRP0) = (1,1), SR1/SR2 can never change again, and a power cycle leaves them as they are.
- R7: A 01h after 06h writes the persistent copy, and the value survives a power cycle. A 01h after 50h writes only the working copy, which a power cycle reloads from the persistent copy. cmd_nbytes gives the number of valid data bytes: SR1 is written from data bits 7..0 when it is at least 1, SR2 from bits 15..8 when it is at least 2, and SR3 from bits 23..16 when it is 3.
- R8: BUSY (SR1 bit 0) follows busy_i in the same cycle. No 01h command changes WEL to 1 or alters SUS (SR2 bit 7).
- R9: Lock bits SR2 bits 5..2 are ORed with the data on an accepted persistent write and never return to 0. A working-copy write leaves them unchanged.
- R10: SR3 is written by 50h then 01h with three data bytes regardless of the protection level. It is untouched by the 06h path and cleared by a power cycle.
- R11: Opcode 75h sets SUS. Opcode 7Ah or a power-cycle pulse clears it. A power-cycle pulse also clears WEL, and in that cycle it takes priority over any command.
- R12: quad_en_o equals QE (SR2 bit 1) and hold_en_o is its inverse. While QE = 1, the protect pin counts as high in the pin-gated level.
- R13: wr_ok_o pulses high for one cycle after each 01h whose SR1/SR2 update was accepted, and stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset to the initial device state |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command |
| cmd_op | input | 8 | Command opcode |
| cmd_data | input | 24 | Data bytes: byte 0 in bits 7..0 (SR1), byte 1 (SR2), byte 2 (SR3) |
| cmd_nbytes | input | 2 | Number of valid data bytes, 0 to 3 |
| wp_n_i | input | 1 | Write-protect pin, active low |
| pwr_cycle_i | input | 1 | One-cycle pulse marking a power-down/power-up |
| busy_i | input | 1 | Busy flag from the array sequencer |
| sr1_o | output | 8 | Status byte 1 |
| sr2_o | output | 8 | Status byte 2 |
| sr3_o | output | 8 | Status byte 3 |
| quad_en_o | output | 1 | Quad data lines enabled |
| hold_en_o | output | 1 | Hold function enabled |
| wr_ok_o | output | 1 | Pulse: last status write accepted |

## Verification
Some properties are checked on every cycle:
- the lock bits never clear and lock bit 0 never drops;
- WEL is set and cleared by the right opcodes;
- an accepted write always had WEL set;
- the pin-gated and power-lock levels reject writes;
- the permanent level holds;
- SUS follows its opcodes and power cycles.

Other behaviour needs a sequence of commands, so only the bench scenarios show it:
- a persistent value surviving a power cycle while a working-copy value is lost;
- SR3 being writable under a lock;
- the (1,0) level unlocking after a power cycle;
- QE overriding the pin.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    localparam int SR_W   = 8;
    localparam int NB_W   = 2;
    localparam int DATA_W = 3 * SR_W;

    // Writable protection/configuration bits per byte
    localparam logic [SR_W-1:0] SR1_PROT_MASK = 8'hFC;
    localparam logic [SR_W-1:0] SR2_PROT_MASK = 8'h43;
    localparam logic [SR_W-1:0] SR2_LOCK_MASK = 8'h3C;
    localparam logic [SR_W-1:0] SR2_RESET     = 8'h04;

    typedef enum logic [1:0] {
        PL_OPEN     = 2'b00,
        PL_PIN      = 2'b01,
        PL_PWR_LOCK = 2'b10,
        PL_FOREVER  = 2'b11
    } prot_level_e;

    typedef struct packed {
        logic wren;
        logic wren_vol;
        logic wrsr;
        logic susp;
        logic resume;
    } cmd_strb_t;

    typedef struct packed {
        logic [SR_W-1:0] nv1;
        logic [SR_W-1:0] nv2;
        logic [SR_W-1:0] v1;
        logic [SR_W-1:0] v2;
        logic [SR_W-1:0] v3;
        logic            wel;
        logic            wvol;
        logic            sus;
        logic            wr_ok;
    } sreg_state_t;

endpackage

// File: rtl/sreg_cmd_decode.sv
module sreg_cmd_decode
    import sreg_pkg::*;
#(
    parameter logic [7:0] OP_WREN     = 8'h06,
    parameter logic [7:0] OP_WREN_VOL = 8'h50,
    parameter logic [7:0] OP_WRSR     = 8'h01,
    parameter logic [7:0] OP_SUSP     = 8'h75,
    parameter logic [7:0] OP_RESUME   = 8'h7A
) (
    input  logic       cmd_valid,
    input  logic [7:0] cmd_op,
    input  logic       pwr_cycle,
    output cmd_strb_t  strb
);

    logic live;

    always_comb begin
        live          = cmd_valid && !pwr_cycle;
        strb.wren     = live && (cmd_op == OP_WREN);
        strb.wren_vol = live && (cmd_op == OP_WREN_VOL);
        strb.wrsr     = live && (cmd_op == OP_WRSR);
        strb.susp     = live && (cmd_op == OP_SUSP);
        strb.resume   = live && (cmd_op == OP_RESUME);
    end

endmodule

// File: rtl/sreg_prot_decode.sv
module sreg_prot_decode
    import sreg_pkg::*;
(
    input  logic srp_hi,
    input  logic srp_lo,
    input  logic wp_n,
    input  logic qe,
    output logic permit
);

    prot_level_e level;
    logic        pin_high;

    always_comb begin
        level    = prot_level_e'({srp_hi, srp_lo});
        pin_high = wp_n || qe;
        unique case (level)
            PL_OPEN:     permit = 1'b1;
            PL_PIN:      permit = pin_high;
            PL_PWR_LOCK: permit = 1'b0;
            PL_FOREVER:  permit = 1'b0;
            default:     permit = 1'b0;
        endcase
    end

endmodule

// File: rtl/sreg_guard.sv
module sreg_guard
    import sreg_pkg::*;
#(
    parameter logic [7:0] OP_WREN     = 8'h06,
    parameter logic [7:0] OP_WREN_VOL = 8'h50,
    parameter logic [7:0] OP_WRSR     = 8'h01,
    parameter logic [7:0] OP_SUSP     = 8'h75,
    parameter logic [7:0] OP_RESUME   = 8'h7A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [NB_W-1:0]   cmd_nbytes,
    input  logic              wp_n_i,
    input  logic              pwr_cycle_i,
    input  logic              busy_i,
    output logic [SR_W-1:0]   sr1_o,
    output logic [SR_W-1:0]   sr2_o,
    output logic [SR_W-1:0]   sr3_o,
    output logic              quad_en_o,
    output logic              hold_en_o,
    output logic              wr_ok_o
);

    sreg_state_t st_d, st_q;
    cmd_strb_t   strb;
    logic        permit;
    logic [SR_W-1:0] b0, b1, b2;
    logic [SR_W-1:0] nv1_pc, nv2_pc, nv1_new, nv2_new;

    sreg_cmd_decode #(
        .OP_WREN    (OP_WREN),
        .OP_WREN_VOL(OP_WREN_VOL),
        .OP_WRSR    (OP_WRSR),
        .OP_SUSP    (OP_SUSP),
        .OP_RESUME  (OP_RESUME)
    ) u_dec (
        .cmd_valid(cmd_valid),
        .cmd_op   (cmd_op),
        .pwr_cycle(pwr_cycle_i),
        .strb     (strb)
    );

    // Decision uses the working copy that the outputs show
    sreg_prot_decode u_prot (
        .srp_hi(st_q.v2[0]),
        .srp_lo(st_q.v1[7]),
        .wp_n  (wp_n_i),
        .qe    (st_q.v2[1]),
        .permit(permit)
    );

    function automatic logic [SR_W-1:0] merge_bits(
        input logic [SR_W-1:0] old_v,
        input logic [SR_W-1:0] new_v,
        input logic [SR_W-1:0] mask
    );
        return (old_v & ~mask) | (new_v & mask);
    endfunction

    always_comb begin
        b0 = cmd_data[SR_W-1:0];
        b1 = cmd_data[2*SR_W-1:SR_W];
        b2 = cmd_data[3*SR_W-1:2*SR_W];

        // Persistent copy as it reappears after a power cycle
        nv1_pc = st_q.nv1;
        nv2_pc = st_q.nv2;
        if (st_q.nv2[0] && !st_q.nv1[7]) begin
            nv2_pc[0] = 1'b0;
        end

        nv1_new = merge_bits(st_q.nv1, b0, SR1_PROT_MASK);
        nv2_new = merge_bits(st_q.nv2, b1, SR2_PROT_MASK) | (b1 & SR2_LOCK_MASK);

        st_d       = st_q;
        st_d.wr_ok = 1'b0;

        if (pwr_cycle_i) begin
            st_d.nv1  = nv1_pc;
            st_d.nv2  = nv2_pc;
            st_d.v1   = nv1_pc;
            st_d.v2   = nv2_pc;
            st_d.v3   = '0;
            st_d.wel  = 1'b0;
            st_d.wvol = 1'b0;
            st_d.sus  = 1'b0;
        end else begin
            if (strb.wren) begin
                st_d.wel  = 1'b1;
                st_d.wvol = 1'b0;
            end
            if (strb.wren_vol) begin
                st_d.wel  = 1'b1;
                st_d.wvol = 1'b1;
            end
            if (strb.susp) begin
                st_d.sus = 1'b1;
            end
            if (strb.resume) begin
                st_d.sus = 1'b0;
            end
            if (strb.wrsr) begin
                st_d.wel = 1'b0;
                if (st_q.wel) begin
                    if (permit && (cmd_nbytes != '0)) begin
                        st_d.wr_ok = 1'b1;
                        if (!st_q.wvol) begin
                            st_d.nv1 = nv1_new;
                            st_d.v1  = nv1_new;
                            if (cmd_nbytes >= NB_W'(2)) begin
                                st_d.nv2 = nv2_new;
                                st_d.v2  = nv2_new;
                            end
                        end else begin
                            st_d.v1 = merge_bits(st_q.v1, b0, SR1_PROT_MASK);
                            if (cmd_nbytes >= NB_W'(2)) begin
                                st_d.v2 = merge_bits(st_q.v2, b1, SR2_PROT_MASK);
                            end
                        end
                    end
                    // Third byte bypasses the protection level
                    if (st_q.wvol && (cmd_nbytes == NB_W'(3))) begin
                        st_d.v3 = b2;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.nv2   <= SR2_RESET;
            st_q.v2    <= SR2_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        sr1_o     = {st_q.v1[SR_W-1:2], st_q.wel, busy_i};
        sr2_o     = {st_q.sus, st_q.v2[SR_W-2:0]};
        sr3_o     = st_q.v3;
        quad_en_o = st_q.v2[1];
        hold_en_o = !st_q.v2[1];
        wr_ok_o   = st_q.wr_ok;
    end

endmodule

// File: rtl/sreg_guard_chk.sv
module sreg_guard_chk #(
    parameter logic [7:0] OP_WREN     = 8'h06,
    parameter logic [7:0] OP_WREN_VOL = 8'h50,
    parameter logic [7:0] OP_WRSR     = 8'h01,
    parameter logic [7:0] OP_SUSP     = 8'h75
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [7:0] cmd_op,
    input logic       wp_n_i,
    input logic       pwr_cycle_i,
    input logic [7:0] sr1_o,
    input logic [7:0] sr2_o,
    input logic       wr_ok_o
);

    logic is_wrsr;
    assign is_wrsr = cmd_valid && (cmd_op == OP_WRSR) && !pwr_cycle_i;

    p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(sr2_o[5:2]) & ~sr2_o[5:2]) == 4'b0000));

    p_lock0_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sr2_o[2]);

    p_wel_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !pwr_cycle_i && (cmd_op == OP_WREN || cmd_op == OP_WREN_VOL)) |=> sr1_o[1]);

    p_wel_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_wrsr |=> !sr1_o[1]);

    p_ok_needs_wel_r13: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok_o |-> ($past(is_wrsr) && $past(sr1_o[1])));

    p_pin_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wrsr && !sr2_o[0] && sr1_o[7] && !wp_n_i && !sr2_o[1]) |=> !wr_ok_o);

    p_lock_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wrsr && sr2_o[0]) |=> !wr_ok_o);

    p_forever_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sr2_o[0] && sr1_o[7]) |=> (sr2_o[0] && sr1_o[7]));

    p_sus_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !pwr_cycle_i && cmd_op == OP_SUSP) |=> sr2_o[7]);

    p_pwr_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_cycle_i |=> (!sr2_o[7] && !sr1_o[1]));

    p_sus_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        is_wrsr |=> (sr2_o[7] == $past(sr2_o[7])));

endmodule

bind sreg_guard sreg_guard_chk #(
    .OP_WREN    (OP_WREN),
    .OP_WREN_VOL(OP_WREN_VOL),
    .OP_WRSR    (OP_WRSR),
    .OP_SUSP    (OP_SUSP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .wp_n_i     (wp_n_i),
    .pwr_cycle_i(pwr_cycle_i),
    .sr1_o      (sr1_o),
    .sr2_o      (sr2_o),
    .wr_ok_o    (wr_ok_o)
);

// File: tb/tb_sreg_guard.sv
module tb_sreg_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_op = 8'h00;
    logic [23:0] cmd_data = 24'h0;
    logic [1:0]  cmd_nbytes = 2'd0;
    logic        wp_n_i = 1'b0;
    logic        pwr_cycle_i = 1'b0;
    logic        busy_i = 1'b0;
    logic [7:0]  sr1_o, sr2_o, sr3_o;
    logic        quad_en_o, hold_en_o, wr_ok_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // Bench model of the device state
    logic [7:0] m_nv1, m_nv2, m_v1, m_v2, m_v3;
    logic       m_wel, m_vol, m_sus, m_ok;

    always #5 clk = ~clk;

    sreg_guard dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .cmd_nbytes(cmd_nbytes), .wp_n_i(wp_n_i),
        .pwr_cycle_i(pwr_cycle_i), .busy_i(busy_i), .sr1_o(sr1_o),
        .sr2_o(sr2_o), .sr3_o(sr3_o), .quad_en_o(quad_en_o),
        .hold_en_o(hold_en_o), .wr_ok_o(wr_ok_o)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_nv1 = 8'h00; m_nv2 = 8'h04; m_v1 = 8'h00; m_v2 = 8'h04; m_v3 = 8'h00;
        m_wel = 0; m_vol = 0; m_sus = 0; m_ok = 0;
    endtask

    task automatic model_pwr();
        if (m_nv2[0] == 1'b1 && m_nv1[7] == 1'b0) m_nv2[0] = 1'b0;
        m_v1 = m_nv1; m_v2 = m_nv2; m_v3 = 8'h00;
        m_wel = 0; m_sus = 0; m_ok = 0;
    endtask

    function automatic logic allowed(input logic wp);
        logic [1:0] lvl;
        lvl = {m_v2[0], m_v1[7]};
        if (lvl == 2'b00) return 1'b1;
        if (lvl == 2'b01) return wp | m_v2[1];
        return 1'b0;
    endfunction

    task automatic model_cmd(input logic [7:0] op, input logic [23:0] d,
                             input logic [1:0] n, input logic wp);
        logic [7:0] s1, s2;
        s1 = d[7:0]; s2 = d[15:8];
        m_ok = 0;
        if (op == 8'h06) begin m_wel = 1; m_vol = 0; end
        else if (op == 8'h50) begin m_wel = 1; m_vol = 1; end
        else if (op == 8'h75) m_sus = 1;
        else if (op == 8'h7A) m_sus = 0;
        else if (op == 8'h01) begin
            if (m_wel) begin
                if (allowed(wp) && n != 2'd0) begin
                    m_ok = 1;
                    if (!m_vol) begin
                        m_nv1 = {s1[7:2], 2'b00};
                        m_v1  = m_nv1;
                        if (n >= 2'd2) begin
                            m_nv2 = {1'b0, s2[6], m_nv2[5:2] | s2[5:2], s2[1:0]};
                            m_v2  = m_nv2;
                        end
                    end else begin
                        m_v1 = {s1[7:2], 2'b00};
                        if (n >= 2'd2) m_v2 = {1'b0, s2[6], m_v2[5:2], s2[1:0]};
                    end
                end
                if (m_vol && n == 2'd3) m_v3 = d[23:16];
            end
            m_wel = 0;
        end
    endtask

    task automatic check_all(input string tag);
        check(sr1_o, {m_v1[7:2], m_wel, busy_i}, tag);
        check(sr2_o, {m_sus, m_v2[6:0]}, tag);
        check(sr3_o, m_v3, tag);
        check({6'd0, quad_en_o, hold_en_o}, {6'd0, m_v2[1], ~m_v2[1]}, tag);
        check({7'd0, wr_ok_o}, {7'd0, m_ok}, tag);
    endtask

    // Called at a negative edge; returns at the next negative edge
    task automatic cmd(input logic [7:0] op, input logic [23:0] d,
                       input logic [1:0] n, input string tag);
        cmd_valid = 1; cmd_op = op; cmd_data = d; cmd_nbytes = n;
        @(posedge clk);
        model_cmd(op, d, n, wp_n_i);
        @(negedge clk);
        cmd_valid = 0;
        check_all(tag);
    endtask

    task automatic pwr(input string tag);
        pwr_cycle_i = 1;
        @(posedge clk);
        model_pwr();
        @(negedge clk);
        pwr_cycle_i = 0;
        check_all(tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(sr1_o, 8'h00, "R1");
        check(sr2_o, 8'h04, "R1");
        check(sr3_o, 8'h00, "R1");
        check({6'd0, quad_en_o, hold_en_o}, 8'h01, "R1");
        check({7'd0, wr_ok_o}, 8'h00, "R1");

        // R2 write without enable ignored
        cmd(8'h01, 24'h00001C, 2'd1, "R2");
        check(sr1_o, 8'h00, "R2");
        cmd(8'h06, 24'h0, 2'd0, "R2");
        check({7'd0, sr1_o[1]}, 8'h01, "R2");
        // R3 open level, pin low ignored
        wp_n_i = 0;
        cmd(8'h01, 24'h00001C, 2'd1, "R3");
        check(sr1_o, 8'h1C, "R3");
        check({7'd0, wr_ok_o}, 8'h01, "R13");
        // R7 working copy lost on power cycle
        cmd(8'h50, 24'h0, 2'd0, "R7");
        cmd(8'h01, 24'h000000, 2'd1, "R7");
        check(sr1_o, 8'h00, "R7");
        pwr("R7");
        check(sr1_o, 8'h1C, "R7");
        // R9 lock bit set, pin level entered
        cmd(8'h06, 24'h0, 2'd0, "R9");
        cmd(8'h01, 24'h000880, 2'd2, "R9");
        check(sr2_o, 8'h0C, "R9");
        check(sr1_o, 8'h80, "R9");
        // R4 pin low rejects
        cmd(8'h06, 24'h0, 2'd0, "R4");
        cmd(8'h01, 24'h000000, 2'd1, "R4");
        check(sr1_o, 8'h80, "R4");
        check({7'd0, wr_ok_o}, 8'h00, "R4");
        // R4 pin high accepts; QE set
        wp_n_i = 1;
        cmd(8'h06, 24'h0, 2'd0, "R4");
        cmd(8'h01, 24'h000280, 2'd2, "R4");
        check(sr2_o, 8'h0E, "R4");
        check({7'd0, quad_en_o}, 8'h01, "R12");
        // R12 QE overrides pin
        wp_n_i = 0;
        cmd(8'h06, 24'h0, 2'd0, "R12");
        cmd(8'h01, 24'h000084, 2'd1, "R12");
        check(sr1_o, 8'h84, "R12");
        // R9 working write keeps locks
        cmd(8'h50, 24'h0, 2'd0, "R9");
        cmd(8'h01, 24'h000280, 2'd2, "R9");
        check(sr2_o, 8'h0E, "R9");
        // R10 third byte
        cmd(8'h50, 24'h0, 2'd0, "R10");
        cmd(8'h01, 24'hA50280, 2'd3, "R10");
        check(sr3_o, 8'hA5, "R10");
        cmd(8'h06, 24'h0, 2'd0, "R10");
        cmd(8'h01, 24'h3C0284, 2'd3, "R10");
        check(sr3_o, 8'hA5, "R10");
        // R11 suspend
        cmd(8'h75, 24'h0, 2'd0, "R11");
        check({7'd0, sr2_o[7]}, 8'h01, "R11");
        cmd(8'h06, 24'h0, 2'd0, "R8");
        cmd(8'h01, 24'h000284, 2'd2, "R8");
        check({7'd0, sr2_o[7]}, 8'h01, "R8");
        cmd(8'h7A, 24'h0, 2'd0, "R11");
        check({7'd0, sr2_o[7]}, 8'h00, "R11");
        cmd(8'h75, 24'h0, 2'd0, "R11");
        pwr("R11");
        check({7'd0, sr2_o[7]}, 8'h00, "R11");
        // R8 busy mirror
        busy_i = 1; #1;
        check({7'd0, sr1_o[0]}, 8'h01, "R8");
        busy_i = 0; #1;
        // R5 power-cycle lock
        cmd(8'h06, 24'h0, 2'd0, "R5");
        cmd(8'h01, 24'h000104, 2'd2, "R5");
        check(sr2_o, 8'h0D, "R5");
        wp_n_i = 1;
        cmd(8'h06, 24'h0, 2'd0, "R5");
        cmd(8'h01, 24'h000000, 2'd2, "R5");
        check({7'd0, wr_ok_o}, 8'h00, "R5");
        cmd(8'h50, 24'h0, 2'd0, "R10");
        cmd(8'h01, 24'h5A0000, 2'd3, "R10");
        check(sr3_o, 8'h5A, "R10");
        pwr("R5");
        check(sr2_o, 8'h0C, "R5");
        check(sr3_o, 8'h00, "R10");
        wp_n_i = 0;
        cmd(8'h06, 24'h0, 2'd0, "R3");
        cmd(8'h01, 24'h000008, 2'd1, "R3");
        check(sr1_o, 8'h08, "R3");

        // Random mix; SR2 bit 0 kept clear so the locked levels stay directed
        for (int i = 0; i < 3000; i++) begin
            int sel;
            logic [23:0] d;
            sel = $urandom_range(0, 11);
            wp_n_i = 1'($urandom);
            busy_i = 1'($urandom);
            d = 24'($urandom) & 24'hFFFEFF;
            case (sel)
                0, 1:    cmd(8'h06, d, 2'($urandom), "R7");
                2, 3:    cmd(8'h50, d, 2'($urandom), "R7");
                4, 5, 6: cmd(8'h01, d, 2'($urandom), "R4");
                7:       cmd(8'h75, d, 2'd0, "R11");
                8:       cmd(8'h7A, d, 2'd0, "R11");
                9:       cmd(8'hA3, d, 2'd3, "R2");
                10:      pwr("R7");
                default: begin @(negedge clk); model_cmd(8'h00, d, 2'd0, wp_n_i); check_all("R8"); end
            endcase
        end

        // R6 permanent lock
        busy_i = 0;
        pwr("R6");
        wp_n_i = 1;
        cmd(8'h06, 24'h0, 2'd0, "R6");
        cmd(8'h01, 24'h000180, 2'd2, "R6");
        check({6'd0, sr2_o[0], sr1_o[7]}, 8'h03, "R6");
        cmd(8'h06, 24'h0, 2'd0, "R6");
        cmd(8'h01, 24'h000000, 2'd2, "R6");
        check({7'd0, wr_ok_o}, 8'h00, "R6");
        pwr("R6");
        check({6'd0, sr2_o[0], sr1_o[7]}, 8'h03, "R6");
        cmd(8'h50, 24'h0, 2'd0, "R6");
        cmd(8'h01, 24'h000000, 2'd2, "R6");
        check({6'd0, sr2_o[0], sr1_o[7]}, 8'h03, "R6");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule